// File: doc/BRIEF.md
# Programmable LED Status Logic Mapper

This block drives an eight-bit LED data byte and a ten-line port-select strobe bus for a time-multiplexed port status display. Outside logic supplies four link status bits for the port being shown: collision, full duplex, and the upper and lower speed bits. It also supplies three activity bits: receive, transmit and flow control. Software writes six 8-bit registers, and these decide the logic formula behind each LED data bit. Four registers build product (AND) terms and one builds a sum (OR) term. In each of them, any status bit can be picked and any picked bit can be negated. The sixth register is a control register. It picks the activity bits that feed the two activity LEDs, can negate the sum term, and holds one global polarity bit. That bit flips the LED data pins and the port-select strobes, always in opposite senses.

An internal scan counter walks through ports 0 to 9 and holds each port for `DWELL` clock cycles. The current index is shown on `scan_port`, so the status source can present the matching port. Both the LED byte and the strobes are registered from the same cycle, so they change on the same edge. Register writes go into shadow copies. A shadow copy moves into the active set only when the scan advances to the next port, so a port slot never shows a half-changed formula.

Top module: `led_status_mapper`

## Requirements
- R1: LED bits 2, 3, 4 and 5 each come from their own formula register, at write addresses 0, 1, 2 and 3. In that register, bit 4+i selects status literal i and bit i negates it. The status index is i=3 for collision, 2 for full duplex, 1 for the upper speed bit and 0 for the lower speed bit. The LED bit is the AND of all selected literals, and it is 1 when no literal is selected.
- R2: LED bit 6 comes from the formula register at address 4, which uses the same field layout as R1. The LED bit is the OR of all selected literals, and it is 0 when no literal is selected. Control register bit 3 set to 1 inverts the OR result.
- R3: LED bit 0 is the OR of the activity bits selected by control bits [2:0]. LED bit 1 is the OR of the activity bits selected by control bits [6:4]. Within each field, bit 2 is receive, bit 1 is transmit and bit 0 is flow control. A field with nothing selected gives 0.
- R4: Control register bit 7 is the global polarity. At 0, the LED bits are active high and the port-select lines are active low. At 1, every LED bit and every port-select line is inverted.
- R5: LED bit 7 always shows the inactive level, which is 0 at polarity 0 and 1 at polarity 1.
- R6: The scan index steps 0, 1, …, 9 and then wraps to 0. Each index is held for exactly DWELL cycles. Exactly one port-select line is active at any time, and that line is the one numbered by the index of the previous cycle.
- R7: The LED byte and the port-select bus are both registered from the same cycle's inputs and configuration. Both therefore show the values of the cycle before.
- R8: The control register is at write address 5. A write to address 6 or 7 changes nothing.
- R9: A write takes effect at the first scan advance edge at or after the write edge. This holds even when the write lands on the advance edge itself. Until that edge, the outputs keep using the previous values.
- R10: During reset and after it, the formula registers are 0 and the control register is 8'h61. While reset is held, the LED byte reads 0 and all port-select lines read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0-4 formula registers, 5 control |
| wr_data | input | 8 | Register write data |
| st_col | input | 1 | Collision status of the displayed port |
| st_fdx | input | 1 | Full-duplex status of the displayed port |
| st_sp1 | input | 1 | Upper speed bit of the displayed port |
| st_sp0 | input | 1 | Lower speed bit of the displayed port |
| act_rx | input | 1 | Receive activity of the displayed port |
| act_tx | input | 1 | Transmit activity of the displayed port |
| act_fc | input | 1 | Flow-control activity of the displayed port |
| scan_port | output | 4 | Index of the port whose status is requested this cycle |
| port_sel | output | 10 | Port-select strobes, one active at a time |
| led_out | output | 8 | LED data byte |

## Verification
The case where two functions fall in the same cycle is a register write that lands on the same edge as the scan advance, which is also the edge where the shadow copy is loaded into the active set. The bench reproduces its own cycle counter and times a formula write to that edge. It then checks that the LED byte still shows the old formula for one more cycle and shows the new formula in the first cycle of the next slot. A second write lands early in a slot, and the bench checks that the old formula holds for the rest of that slot. Around these directed cases, a sweep drives all 128 status and activity patterns under more than twenty computed register sets. In each cycle it compares the LED byte and the strobe bus with values computed in the bench.

// File: rtl/led_map_pkg.sv
// Package: shared widths and formula helpers for the LED status mapper.
// Assumes status literals are ordered {collision, full duplex, speed1, speed0}.
package led_map_pkg;
    localparam int STAT_W  = 4;   // status literals per formula
    localparam int ACT_W   = 3;   // activity bits per activity field
    localparam int LED_W   = 8;   // LED byte width
    localparam int CFG_W   = 8;   // register width
    localparam int NUM_AND = 4;   // product-term LED bits
    localparam int NUM_FRM = NUM_AND + 1;  // formula registers incl. sum term
    localparam logic [CFG_W-1:0] CTL_RESET = 8'h61;

    // Product of selected, polarity-adjusted literals; empty selection gives 1.
    function automatic logic prod_term(input logic [CFG_W-1:0] cfg,
                                       input logic [STAT_W-1:0] st);
        logic [STAT_W-1:0] lit;
        lit = st ^ cfg[STAT_W-1:0];
        return &(lit | ~cfg[CFG_W-1:STAT_W]);
    endfunction

    // Sum of selected, polarity-adjusted literals; empty selection gives 0.
    function automatic logic sum_term(input logic [CFG_W-1:0] cfg,
                                      input logic [STAT_W-1:0] st);
        logic [STAT_W-1:0] lit;
        lit = st ^ cfg[STAT_W-1:0];
        return |(lit & cfg[CFG_W-1:STAT_W]);
    endfunction
endpackage

// File: rtl/led_cfg_regs.sv
// Module: shadow and active copies of the formula and control registers.
// Writes land in the shadow copy; the active copy reloads on slot_adv,
// taking a write made on that same edge. Addresses above the control
// register are ignored.
module led_cfg_regs
    import led_map_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CFG_W-1:0]               wr_data,
    input  logic                           slot_adv,
    output logic [NUM_FRM-1:0][CFG_W-1:0]  frm_act,
    output logic [CFG_W-1:0]               ctl_act
);
    localparam int NUM_REG = NUM_FRM + 1;

    logic [NUM_REG-1:0][CFG_W-1:0] shd_q;
    logic [NUM_REG-1:0][CFG_W-1:0] shd_nxt;
    logic [NUM_REG-1:0][CFG_W-1:0] act_q;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        localparam logic [CFG_W-1:0] RST_V = (r == NUM_FRM) ? CTL_RESET : '0;

        // Next shadow value: write data when this register is addressed.
        always_comb begin
            shd_nxt[r] = (wr_en && wr_addr == ADDR_W'(r)) ? wr_data : shd_q[r];
        end

        // Shadow register holds the latest written value.
        always_ff @(posedge clk) begin
            if (!rst_n) shd_q[r] <= RST_V;
            else        shd_q[r] <= shd_nxt[r];
        end

        // Active register reloads only on a scan slot advance.
        always_ff @(posedge clk) begin
            if (!rst_n)        act_q[r] <= RST_V;
            else if (slot_adv) act_q[r] <= shd_nxt[r];
        end
    end

    for (genvar f = 0; f < NUM_FRM; f++) begin : g_out
        assign frm_act[f] = act_q[f];
    end
    assign ctl_act = act_q[NUM_FRM];
endmodule

// File: rtl/led_scan_ctr.sv
// Module: port scan counter. Holds each port index for DWELL cycles, then
// advances it modulo NUM_PORTS. slot_adv marks the last cycle of a slot.
module led_scan_ctr #(
    parameter int NUM_PORTS = 10,
    parameter int DWELL     = 4,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int DWELL_W  = (DWELL > 1) ? $clog2(DWELL) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PORT_W-1:0]  port_idx,
    output logic [DWELL_W-1:0] dwell_cnt,
    output logic               slot_adv
);
    localparam logic [DWELL_W-1:0] DW_LAST = DWELL_W'(DWELL - 1);
    localparam logic [PORT_W-1:0]  PT_LAST = PORT_W'(NUM_PORTS - 1);

    // Slot ends when the dwell count reaches its final value.
    always_comb begin
        slot_adv = (dwell_cnt == DW_LAST);
    end

    // Dwell counter within one port slot.
    always_ff @(posedge clk) begin
        if (!rst_n)        dwell_cnt <= '0;
        else if (slot_adv) dwell_cnt <= '0;
        else               dwell_cnt <= dwell_cnt + 1'b1;
    end

    // Port index, stepping and wrapping on each slot advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                 port_idx <= '0;
        else if (slot_adv) begin
            if (port_idx == PT_LAST) port_idx <= '0;
            else                     port_idx <= port_idx + 1'b1;
        end
    end
endmodule

// File: rtl/led_formula.sv
// Module: combinational LED byte formation from status, activity and the
// active configuration, including global polarity. Bit 7 is unused and
// carries the inactive level.
module led_formula
    import led_map_pkg::*;
(
    input  logic [NUM_FRM-1:0][CFG_W-1:0] frm_act,
    input  logic [CFG_W-1:0]              ctl_act,
    input  logic [STAT_W-1:0]             status,
    input  logic [ACT_W-1:0]              activity,
    output logic [LED_W-1:0]              led_nxt
);
    logic [LED_W-1:0] raw;

    // Product-term LED bits 2..5.
    for (genvar k = 0; k < NUM_AND; k++) begin : g_prod
        assign raw[k+2] = prod_term(frm_act[k], status);
    end

    // Sum-term bit, activity bits and reserved bit.
    always_comb begin
        raw[NUM_AND+2] = sum_term(frm_act[NUM_AND], status) ^ ctl_act[3];
        raw[0]         = |(activity & ctl_act[2:0]);
        raw[1]         = |(activity & ctl_act[6:4]);
        raw[LED_W-1]   = 1'b0;
    end

    // Global polarity applied to the whole byte.
    always_comb begin
        led_nxt = raw ^ {LED_W{ctl_act[CFG_W-1]}};
    end
endmodule

// File: rtl/led_status_mapper.sv
// Module: top of the LED status mapper. Assumes the status inputs belong
// to the port on scan_port in the same cycle. LED byte and port strobes
// are registered together so they change on the same edge.
module led_status_mapper
    import led_map_pkg::*;
#(
    parameter int NUM_PORTS = 10,
    parameter int DWELL     = 4,
    parameter int ADDR_W    = 3,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int DWELL_W  = (DWELL > 1) ? $clog2(DWELL) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  st_col,
    input  logic                  st_fdx,
    input  logic                  st_sp1,
    input  logic                  st_sp0,
    input  logic                  act_rx,
    input  logic                  act_tx,
    input  logic                  act_fc,
    output logic [PORT_W-1:0]     scan_port,
    output logic [NUM_PORTS-1:0]  port_sel,
    output logic [7:0]            led_out
);
    logic                          slot_adv;
    logic [DWELL_W-1:0]            dwell_cnt;
    logic [NUM_FRM-1:0][CFG_W-1:0] frm_act;
    logic [CFG_W-1:0]              ctl_act;
    logic [LED_W-1:0]              led_nxt;
    logic [NUM_PORTS-1:0]          sel_hot;

    led_scan_ctr #(.NUM_PORTS(NUM_PORTS), .DWELL(DWELL)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_idx  (scan_port),
        .dwell_cnt (dwell_cnt),
        .slot_adv  (slot_adv)
    );

    led_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .slot_adv (slot_adv),
        .frm_act  (frm_act),
        .ctl_act  (ctl_act)
    );

    led_formula u_form (
        .frm_act  (frm_act),
        .ctl_act  (ctl_act),
        .status   ({st_col, st_fdx, st_sp1, st_sp0}),
        .activity ({act_rx, act_tx, act_fc}),
        .led_nxt  (led_nxt)
    );

    // One-hot decode of the current scan index.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hot
        assign sel_hot[p] = (scan_port == PORT_W'(p));
    end

    // Output registers: LED byte and strobes, opposite polarity senses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_out  <= '0;
            port_sel <= '1;
        end else begin
            led_out  <= led_nxt;
            port_sel <= sel_hot ^ {NUM_PORTS{~ctl_act[CFG_W-1]}};
        end
    end
endmodule

// File: rtl/led_map_checker.sv
// Module: assertion checker for led_status_mapper, attached with bind.
module led_map_checker
    import led_map_pkg::*;
#(
    parameter int NUM_PORTS = 10,
    parameter int DWELL     = 4,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int DWELL_W  = (DWELL > 1) ? $clog2(DWELL) : 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_PORTS-1:0]          port_sel,
    input logic [7:0]                    led_out,
    input logic [PORT_W-1:0]             scan_port,
    input logic                          slot_adv,
    input logic [DWELL_W-1:0]            dwell_cnt,
    input logic [CFG_W-1:0]              cfg_ctl,
    input logic [NUM_FRM-1:0][CFG_W-1:0] cfg_form
);
    localparam logic [PORT_W-1:0] PT_LAST = PORT_W'(NUM_PORTS - 1);

    AST_ONE_PORT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(port_sel ^ {NUM_PORTS{~$past(cfg_ctl[7])}}) == 1); // R6
    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_adv |=> $stable(scan_port)); // R6
    AST_PORT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        slot_adv |=> scan_port == (($past(scan_port) == PT_LAST) ? '0 : $past(scan_port) + 1'b1)); // R6
    AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, dwell_cnt} < (DWELL_W+1)'(DWELL)); // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_adv |=> $stable(cfg_ctl) && $stable(cfg_form)); // R9
    AST_LED7_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> led_out[7] == $past(cfg_ctl[7])); // R5
    AST_EMPTY_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_form[0][7:4]) == 4'b0) |-> led_out[2] == !$past(cfg_ctl[7])); // R1
endmodule

bind led_status_mapper led_map_checker #(.NUM_PORTS(NUM_PORTS), .DWELL(DWELL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_sel  (port_sel),
    .led_out   (led_out),
    .scan_port (scan_port),
    .slot_adv  (slot_adv),
    .dwell_cnt (dwell_cnt),
    .cfg_ctl   (ctl_act),
    .cfg_form  (frm_act)
);

// File: tb/test_led_status_mapper.sv
// Bench: near-exhaustive sweep of status/activity patterns under many
// computed register sets, plus directed write-timing and reset checks.
module test_led_status_mapper;
    localparam int NP = 10;
    localparam int D  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] st = '0;
    logic [2:0] act = '0;
    logic [3:0] scan_port;
    logic [NP-1:0] port_sel;
    logic [7:0] led_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [4:0][7:0] sh_f = '0;
    logic [7:0]      sh_c = 8'h61;

    always #5 clk = ~clk;

    led_status_mapper #(.NUM_PORTS(NP), .DWELL(D)) i_led_status_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .st_col(st[3]), .st_fdx(st[2]), .st_sp1(st[1]), .st_sp0(st[0]),
        .act_rx(act[2]), .act_tx(act[1]), .act_fc(act[0]),
        .scan_port(scan_port), .port_sel(port_sel), .led_out(led_out)
    );

    // Edge counter since reset release.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    function automatic logic [7:0] exp_led(input logic [4:0][7:0] f, input logic [7:0] c,
                                           input logic [3:0] s, input logic [2:0] a);
        logic [7:0] r;
        logic acc;
        r = '0;
        r[0] = (a[2] & c[2]) | (a[1] & c[1]) | (a[0] & c[0]);
        r[1] = (a[2] & c[6]) | (a[1] & c[5]) | (a[0] & c[4]);
        for (int k = 0; k < 4; k++) begin
            acc = 1'b1;
            for (int b = 0; b < 4; b++) if (f[k][b+4]) acc = acc & (s[b] ^ f[k][b]);
            r[k+2] = acc;
        end
        acc = 1'b0;
        for (int b = 0; b < 4; b++) if (f[4][b+4]) acc = acc | (s[b] ^ f[4][b]);
        r[6] = acc ^ c[3];
        return c[7] ? ~r : r;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 3'd5) sh_f[a] = d;
        else if (a == 3'd5) sh_c = d;
    endtask

    task automatic settle();
        repeat (D + 2) @(negedge clk);
    endtask

    // Drive all 128 input patterns; check LED byte, strobes and index each cycle.
    task automatic sweep(input string req);
        logic [6:0] p;
        logic [NP-1:0] es;
        for (int i = 0; i <= 128; i++) begin
            if (i > 0) begin
                chk(req, {24'b0, led_out}, {24'b0, exp_led(sh_f, sh_c, p[3:0], p[6:4])});
                es = (NP'(1) << (((cyc - 1) / D) % NP)) ^ {NP{~sh_c[7]}};
                chk("R6 port_sel", {22'b0, port_sel}, {22'b0, es});
                chk("R6 scan_port", {28'b0, scan_port}, 32'((cyc / D) % NP));
            end
            p = 7'(i);
            st = p[3:0]; act = p[6:4];
            @(negedge clk);
        end
    endtask

    // Write reg0 so it lands on edge cyc+1; check old value until the slot advance, then new.
    task automatic switch_test(input logic [7:0] nv, input string req);
        logic [4:0][7:0] old_f;
        int w, b;
        old_f = sh_f;
        w = cyc + 1;
        b = ((w + D - 1) / D) * D;
        do_wr(3'd0, nv);
        while (cyc <= b + 1) begin
            chk(req, {24'b0, led_out},
                {24'b0, exp_led((cyc <= b) ? old_f : sh_f, sh_c, st, act)});
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset led", {24'b0, led_out}, 32'h0);
        chk("R10 reset port_sel", {22'b0, port_sel}, {22'b0, {NP{1'b1}}});
        rst_n = 1'b1;
        sweep("R10 R3 defaults");
        for (int c = 0; c < 24; c++) begin
            for (int k = 0; k < 5; k++) do_wr(3'(k), 8'((c * 53 + k * 29 + 7) & 255));
            do_wr(3'd5, 8'((c * 71 + 13) & 255));
            settle();
            sweep(c[0] ? "R1 R2 R3 R4 R5 R7 sweep" : "R1 R2 R4 R6 R7 sweep");
        end
        // Ignored addresses.
        do_wr(3'd6, 8'hFF);
        do_wr(3'd7, 8'hFF);
        settle();
        sweep("R8 addr 6/7 ignored");
        // Write landing on the advance edge, then one early in a slot.
        do_wr(3'd5, 8'h61);
        do_wr(3'd0, 8'h88);
        settle();
        st = 4'b1000; act = '0;
        while (((cyc + 1) % D) != 0) @(negedge clk);
        switch_test(8'h80, "R9 write on advance edge");
        while (((cyc + 1) % D) != 1) @(negedge clk);
        switch_test(8'h88, "R9 write mid slot");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule